// File: doc/BRIEF.md
# Nested Two-Stage Page Walker

This block resolves a translation miss when two levels of address mapping are active. A guest-virtual address is first mapped by the guest's own four-level tables into a guest-physical address. Every guest-physical address the walk touches is then mapped by a separate four-level host table set into a host-physical address. This applies both to the guest table pages and to the final guest-physical page. The walker issues one 64-bit table read at a time over a plain request/response memory port. When it finishes, it reports either the host-physical frame of the page or a fault that names the failing stage, level and address.

The root of the top guest table is supplied as a host frame. The host table root is supplied as a host frame as well. Both roots are sampled when a walk is accepted. Nothing is cached between walks, so the guest may rewrite its tables at any time without any trap, and the next walk sees the change. A complete miss costs four guest reads and sixteen host reads.

Top module: `xlat_nested_walker`

## Requirements
- R1: Out of reset, walk_busy, walk_done, walk_fault and mem_req_valid are all low.
- R2: A table entry is 64 bits. Bit 0 is the present flag and bits 51:12 hold the next frame. A table read goes to byte address {table frame, 9-bit index, 3'b000}. At guest level L (3 is the top level, 0 is the leaf), the index is guest-virtual bits [12+9L+8 : 12+9L]. The guest walk starts at guest_root_frame with level 3.
- R3: Every guest entry's frame is guest-physical and is translated by a complete host walk before it is used. The walk starts at host_root_frame with level 3, and the index at level L is guest-physical bits [12+9L+8 : 12+9L]. The final host leaf frame is the result. A complete miss issues 20 reads in the order guest, host×4, repeated four times. Exactly 16 of these have mem_req_host=1.
- R4: mem_req_valid is high for one cycle per read. No new read is issued until mem_rsp_valid answers it. A mem_rsp_valid that arrives while no read is pending has no effect.
- R5: walk_req is accepted only while walk_busy is low. A walk_req raised during a walk is ignored and is not queued.
- R6: walk_done and walk_fault are single-cycle pulses that never coincide. result_frame is valid with walk_done.
- R7: A guest entry with bit 0 clear ends the walk with walk_fault=1 and fault_nested=0. fault_level is the guest level and fault_addr is the guest-virtual address zero-extended to 52 bits. No further reads are issued.
- R8: A host entry with bit 0 clear ends the walk with walk_fault=1 and fault_nested=1. fault_level is the host level and fault_addr is the guest-physical page being translated, which is {frame, 12'b0}.
- R9: Each walk reads the tables as they currently stand in memory. An entry rewritten between two walks changes the second result.
- R10: A walk_req raised in the same cycle as a walk_done or walk_fault pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_req | input | 1 | Start a walk (taken only when idle) |
| walk_gva | input | 48 | Guest-virtual address to translate |
| guest_root_frame | input | 40 | Host frame of the top guest table |
| host_root_frame | input | 40 | Host frame of the top host table |
| walk_busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Table read request, one cycle |
| mem_req_host | output | 1 | Request belongs to the host stage |
| mem_req_addr | output | 52 | Host-physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry read |
| walk_done | output | 1 | Successful completion pulse |
| walk_fault | output | 1 | Fault pulse |
| fault_nested | output | 1 | Fault came from the host stage |
| fault_level | output | 2 | Level of the absent entry |
| fault_addr | output | 52 | Faulting guest-virtual or guest-physical address |
| result_frame | output | 40 | Host-physical frame of the translated page |

## Verification
A completion or fault pulse can fall in the same cycle as a new walk request. The walker returns to idle at the edge that raises the pulse. The bench therefore raises walk_req in the very cycle it sees walk_done, and again in the cycle it sees walk_fault. It judges the outcome by walk_busy being high one cycle later and by the second walk returning its own frame. A stray response while idle, and a request injected mid-walk, are each judged at the ports by the absence of any pulse or read, and by an unchanged result.

// File: rtl/nw_pkg.sv
package nw_pkg;
  localparam int NW_LEVELS = 4;
  localparam int IDX_W     = 9;
  localparam int ENTRY_W   = 64;
  localparam int PA_W      = 52;
  localparam int VA_W      = 48;
  localparam int OFS_W     = $clog2(ENTRY_W / 8);
  localparam int PG_SHIFT  = IDX_W + OFS_W;
  localparam int FRAME_W   = PA_W - PG_SHIFT;
  localparam int LVL_W     = $clog2(NW_LEVELS);
  localparam int FULL_HOST_READS = NW_LEVELS * NW_LEVELS;
  localparam int CNT_W     = $clog2(FULL_HOST_READS + 1) + 1;

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [ENTRY_W-1:0] entry_t;
  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [PA_W-1:0]    paddr_t;
  typedef logic [VA_W-1:0]    vaddr_t;
  typedef logic [IDX_W-1:0]   idx_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GREQ, ST_GWAIT, ST_HREQ, ST_HWAIT
  } wst_t;

  localparam lvl_t TOP_LVL = lvl_t'(NW_LEVELS - 1);

  // index of a guest-virtual address at a level
  function automatic idx_t va_index(input vaddr_t va, input lvl_t lvl);
    return va[PG_SHIFT + IDX_W * int'(lvl) +: IDX_W];
  endfunction

  // index of a guest-physical frame at a level
  function automatic idx_t pa_index(input frame_t f, input lvl_t lvl);
    return f[IDX_W * int'(lvl) +: IDX_W];
  endfunction

  function automatic paddr_t tbl_addr(input frame_t f, input idx_t i);
    return {f, i, {OFS_W{1'b0}}};
  endfunction

  function automatic logic ent_present(input entry_t e);
    return e[0];
  endfunction

  function automatic frame_t ent_frame(input entry_t e);
    return e[PA_W-1:PG_SHIFT];
  endfunction

  function automatic paddr_t va_widen(input vaddr_t va);
    return {{(PA_W - VA_W){1'b0}}, va};
  endfunction

  function automatic paddr_t frame_base(input frame_t f);
    return {f, {PG_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/nw_seq.sv
module nw_seq
  import nw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   walk_req,
  input  vaddr_t walk_gva,
  input  frame_t guest_root_frame,
  input  frame_t host_root_frame,
  input  logic   mem_rsp_valid,
  input  entry_t mem_rsp_data,
  output wst_t   st,
  output lvl_t   g_lvl,
  output lvl_t   h_lvl,
  output frame_t gtab_frame,
  output frame_t htab_frame,
  output frame_t tgt_frame,
  output vaddr_t gva_q,
  output frame_t ent_fr,
  output logic   ev_start,
  output logic   ev_done,
  output logic   ev_gfault,
  output logic   ev_hfault
);
  frame_t hroot_q;
  logic   rsp_take;
  logic   ent_ok;
  logic   unused_rsp_bits;

  assign unused_rsp_bits = ^mem_rsp_data;
  assign rsp_take  = mem_rsp_valid && (st == ST_GWAIT || st == ST_HWAIT);
  assign ent_ok    = ent_present(mem_rsp_data);
  assign ent_fr    = ent_frame(mem_rsp_data);
  assign ev_start  = walk_req && (st == ST_IDLE);
  assign ev_gfault = rsp_take && (st == ST_GWAIT) && !ent_ok;
  assign ev_hfault = rsp_take && (st == ST_HWAIT) && !ent_ok;
  assign ev_done   = rsp_take && (st == ST_HWAIT) && ent_ok &&
                     (h_lvl == '0) && (g_lvl == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      g_lvl      <= '0;
      h_lvl      <= '0;
      gtab_frame <= '0;
      htab_frame <= '0;
      tgt_frame  <= '0;
      hroot_q    <= '0;
      gva_q      <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (walk_req) begin
          gva_q      <= walk_gva;
          gtab_frame <= guest_root_frame;
          hroot_q    <= host_root_frame;
          g_lvl      <= TOP_LVL;
          st         <= ST_GREQ;
        end
        ST_GREQ: st <= ST_GWAIT;
        ST_GWAIT: if (rsp_take) begin
          if (!ent_ok) st <= ST_IDLE;
          else begin
            tgt_frame  <= ent_fr;
            h_lvl      <= TOP_LVL;
            htab_frame <= hroot_q;
            st         <= ST_HREQ;
          end
        end
        ST_HREQ: st <= ST_HWAIT;
        ST_HWAIT: if (rsp_take) begin
          if (!ent_ok) st <= ST_IDLE;
          else if (h_lvl != '0) begin
            htab_frame <= ent_fr;
            h_lvl      <= h_lvl - 1'b1;
            st         <= ST_HREQ;
          end else if (g_lvl != '0) begin
            gtab_frame <= ent_fr;
            g_lvl      <= g_lvl - 1'b1;
            st         <= ST_GREQ;
          end else st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: a host walk always begins at the top level
  p_host_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GWAIT && rsp_take && ent_ok) |=> (st == ST_HREQ && h_lvl == TOP_LVL));

  // R7: an absent guest entry returns the walker to idle
  p_gfault_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gfault |=> (st == ST_IDLE));
endmodule

// File: rtl/nw_addr.sv
module nw_addr
  import nw_pkg::*;
(
  input  wst_t   st,
  input  lvl_t   g_lvl,
  input  lvl_t   h_lvl,
  input  frame_t gtab_frame,
  input  frame_t htab_frame,
  input  frame_t tgt_frame,
  input  vaddr_t gva_q,
  output logic   req_valid,
  output logic   req_host,
  output paddr_t req_addr
);
  paddr_t g_addr;
  paddr_t h_addr;

  assign g_addr    = tbl_addr(gtab_frame, va_index(gva_q, g_lvl));
  assign h_addr    = tbl_addr(htab_frame, pa_index(tgt_frame, h_lvl));
  assign req_host  = (st == ST_HREQ);
  assign req_valid = (st == ST_GREQ) || req_host;
  assign req_addr  = req_host ? h_addr : g_addr;
endmodule

// File: rtl/nw_report.sv
module nw_report
  import nw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_done,
  input  logic   ev_gfault,
  input  logic   ev_hfault,
  input  frame_t ent_fr,
  input  lvl_t   g_lvl,
  input  lvl_t   h_lvl,
  input  vaddr_t gva_q,
  input  frame_t tgt_frame,
  output logic   done,
  output logic   fault,
  output logic   nested,
  output lvl_t   flvl,
  output paddr_t faddr,
  output frame_t result
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      fault  <= 1'b0;
      nested <= 1'b0;
      flvl   <= '0;
      faddr  <= '0;
      result <= '0;
    end else begin
      done  <= ev_done;
      fault <= ev_gfault | ev_hfault;
      if (ev_done) result <= ent_fr;
      if (ev_gfault) begin
        nested <= 1'b0;
        flvl   <= g_lvl;
        faddr  <= va_widen(gva_q);
      end else if (ev_hfault) begin
        nested <= 1'b1;
        flvl   <= h_lvl;
        faddr  <= frame_base(tgt_frame);
      end
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  p_gfault_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !nested) |-> (faddr == va_widen(gva_q)));

  p_nfault_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && nested) |-> (faddr[PG_SHIFT-1:0] == '0));
endmodule

// File: rtl/xlat_nested_walker.sv
module xlat_nested_walker
  import nw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               walk_req,
  input  logic [VA_W-1:0]    walk_gva,
  input  logic [FRAME_W-1:0] guest_root_frame,
  input  logic [FRAME_W-1:0] host_root_frame,
  output logic               walk_busy,
  output logic               mem_req_valid,
  output logic               mem_req_host,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               walk_done,
  output logic               walk_fault,
  output logic               fault_nested,
  output logic [LVL_W-1:0]   fault_level,
  output logic [PA_W-1:0]    fault_addr,
  output logic [FRAME_W-1:0] result_frame
);
  wst_t   st;
  lvl_t   g_lvl, h_lvl;
  frame_t gtab_frame, htab_frame, tgt_frame, ent_fr;
  vaddr_t gva_q;
  logic   ev_start, ev_done, ev_gfault, ev_hfault;

  nw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .walk_req(walk_req), .walk_gva(walk_gva),
    .guest_root_frame(guest_root_frame), .host_root_frame(host_root_frame),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .st(st), .g_lvl(g_lvl), .h_lvl(h_lvl), .gtab_frame(gtab_frame),
    .htab_frame(htab_frame), .tgt_frame(tgt_frame), .gva_q(gva_q),
    .ent_fr(ent_fr), .ev_start(ev_start), .ev_done(ev_done),
    .ev_gfault(ev_gfault), .ev_hfault(ev_hfault)
  );

  nw_addr u_addr (
    .st(st), .g_lvl(g_lvl), .h_lvl(h_lvl), .gtab_frame(gtab_frame),
    .htab_frame(htab_frame), .tgt_frame(tgt_frame), .gva_q(gva_q),
    .req_valid(mem_req_valid), .req_host(mem_req_host), .req_addr(mem_req_addr)
  );

  nw_report u_report (
    .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_gfault(ev_gfault),
    .ev_hfault(ev_hfault), .ent_fr(ent_fr), .g_lvl(g_lvl), .h_lvl(h_lvl),
    .gva_q(gva_q), .tgt_frame(tgt_frame), .done(walk_done), .fault(walk_fault),
    .nested(fault_nested), .flvl(fault_level), .faddr(fault_addr),
    .result(result_frame)
  );

  assign walk_busy = (st != ST_IDLE);

  // Independent observers for the assertions
  logic             pend_q;
  logic [CNT_W-1:0] host_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      host_cnt <= '0;
    end else begin
      if (pend_q && mem_rsp_valid) pend_q <= 1'b0;
      else if (mem_req_valid)      pend_q <= 1'b1;
      if (ev_start) host_cnt <= '0;
      else if (mem_req_valid && mem_req_host) host_cnt <= host_cnt + 1'b1;
    end
  end

  p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !pend_q);

  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  p_req_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> walk_busy);

  p_start_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walk_busy) |-> $past(walk_req));

  p_host_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> (host_cnt == CNT_W'(FULL_HOST_READS)));
endmodule

// File: tb/xlat_nested_walker_bench.sv
module xlat_nested_walker_bench;
  localparam logic [39:0] HROOT = 40'h100;
  localparam logic [39:0] GROOT = 40'h101;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        walk_req = 1'b0;
  logic [47:0] walk_gva = '0;
  logic        walk_busy, mem_req_valid, mem_req_host;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        walk_done, walk_fault, fault_nested;
  logic [1:0]  fault_level;
  logic [51:0] fault_addr;
  logic [39:0] result_frame;

  xlat_nested_walker u_xlat_nested_walker (
    .clk(clk), .rst_n(rst_n), .walk_req(walk_req), .walk_gva(walk_gva),
    .guest_root_frame(GROOT), .host_root_frame(HROOT), .walk_busy(walk_busy),
    .mem_req_valid(mem_req_valid), .mem_req_host(mem_req_host),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .walk_done(walk_done), .walk_fault(walk_fault),
    .fault_nested(fault_nested), .fault_level(fault_level),
    .fault_addr(fault_addr), .result_frame(result_frame)
  );

  logic [63:0] mem  [logic [51:0]];
  logic [39:0] hmap [logic [39:0]];
  logic [39:0] next_hframe = 40'h200;
  logic [39:0] next_gtab   = 40'h10000;
  logic [39:0] next_gtab_h = 40'h3000;

  int n_chk = 0, n_bad = 0;
  int rd_all = 0, rd_host = 0, lat_sel = 0, wctr = 0;
  logic [31:0] hpat = '0;
  logic [51:0] raddr = '0;
  bit stray = 1'b0;

  function automatic logic [63:0] mk_ent(input logic [39:0] f);
    return {12'h0, f, 11'h0, 1'b1};
  endfunction

  function automatic logic [39:0] fr(input logic [63:0] e);
    return e[51:12];
  endfunction

  task automatic check(input bit ok, input string rq,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic map_host(input logic [39:0] g, input logic [39:0] h);
    logic [39:0] cur;
    logic [51:0] a;
    cur = HROOT;
    for (int l = 3; l > 0; l--) begin
      a = {cur, g[9*l +: 9], 3'b000};
      if (!mem.exists(a)) begin
        mem[a] = mk_ent(next_hframe);
        next_hframe++;
      end
      cur = fr(mem[a]);
    end
    mem[{cur, g[8:0], 3'b000}] = mk_ent(h);
    hmap[g] = h;
  endtask

  task automatic map_guest(input logic [35:0] vp, input logic [39:0] gpa);
    logic [39:0] cur;
    logic [51:0] a;
    cur = GROOT;
    for (int l = 3; l > 0; l--) begin
      a = {cur, vp[9*l +: 9], 3'b000};
      if (!mem.exists(a)) begin
        map_host(next_gtab, next_gtab_h);
        mem[a] = mk_ent(next_gtab);
        next_gtab++;
        next_gtab_h++;
      end
      cur = hmap[fr(mem[a])];
    end
    mem[{cur, vp[8:0], 3'b000}] = mk_ent(gpa);
  endtask

  // memory responder: latency 1..3 cycles, reads live contents
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (stray) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mk_ent(40'h55);
        stray = 1'b0;
      end
      if (wctr > 0) begin
        wctr--;
        if (wctr == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem.exists(raddr) ? mem[raddr] : 64'h0;
        end
      end
      if (mem_req_valid) begin
        raddr = mem_req_addr;
        rd_all++;
        if (mem_req_host) rd_host++;
        hpat = {hpat[30:0], mem_req_host};
        wctr = 1 + (lat_sel % 3);
        lat_sel++;
      end
    end
  end

  task automatic launch(input logic [47:0] g);
    rd_all = 0;
    rd_host = 0;
    hpat = '0;
    walk_gva = g;
    walk_req = 1'b1;
    @(negedge clk);
    walk_req = 1'b0;
  endtask

  task automatic wait_end;
    do @(negedge clk); while (!(walk_done || walk_fault));
  endtask

  function automatic logic [35:0] sweep_vp(input int i);
    return {9'(i % 3), 9'(i % 4), 9'(i % 2), 9'(i)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R4 watchdog act=%0h exp=%0h", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] g;
    logic [35:0] vp;
    for (int i = 0; i < 16; i++) begin
      map_host(40'h1000 + 40'(i * 7), 40'h9000 + 40'(i * 13));
      map_guest(sweep_vp(i), 40'h1000 + 40'(i * 7));
    end

    repeat (5) @(negedge clk);
    check(!walk_busy && !walk_done && !walk_fault && !mem_req_valid, "R1 reset outputs",
          {walk_busy, walk_done, walk_fault, mem_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!walk_busy && !mem_req_valid, "R1 idle after reset",
          {walk_busy, mem_req_valid}, 0);

    // R2 R3: sweep over guest pages
    for (int i = 0; i < 16; i++) begin
      g = {sweep_vp(i), 12'(i * 12'h111)};
      launch(g);
      wait_end();
      check(walk_done && !walk_fault, "R3 done", {walk_done, walk_fault}, 2'b10);
      check(result_frame == 40'h9000 + 40'(i * 13), "R2 R3 result frame",
            result_frame, 40'h9000 + 40'(i * 13));
      check(rd_all == 20 && rd_host == 16, "R3 read counts",
            {rd_all[15:0], rd_host[15:0]}, {16'd20, 16'd16});
      if (i == 0)
        check(hpat == 32'h7BDEF, "R3 read order", hpat, 32'h7BDEF);
      @(negedge clk);
      check(!walk_done, "R6 done single pulse", walk_done, 0);
    end

    // R10: request in the completion cycle
    launch({sweep_vp(1), 12'h0});
    wait_end();
    launch({sweep_vp(2), 12'h0});
    check(walk_busy, "R10 taken on done cycle", walk_busy, 1);
    wait_end();
    check(walk_done && result_frame == 40'h9000 + 40'd26, "R10 second result",
          result_frame, 40'h9000 + 40'd26);
    @(negedge clk);

    // R7: guest fault at top level, then R10 on the fault cycle
    g = {9'h1FF, 27'h0, 12'h345};
    launch(g);
    wait_end();
    check(walk_fault && !walk_done && !fault_nested, "R7 guest fault flags",
          {walk_fault, walk_done, fault_nested}, 3'b100);
    check(fault_level == 2'd3 && fault_addr == {4'h0, g}, "R7 top level/addr",
          {fault_level, fault_addr}, {2'd3, 4'h0, g});
    check(rd_all == 1, "R7 reads stop", rd_all, 1);
    launch({sweep_vp(3), 12'h0});
    check(walk_busy, "R10 taken on fault cycle", walk_busy, 1);
    wait_end();
    check(walk_done && result_frame == 40'h9000 + 40'd39, "R10 result after fault",
          result_frame, 40'h9000 + 40'd39);
    @(negedge clk);

    // R7: guest leaf absent
    g = {9'd0, 9'd0, 9'd0, 9'h100, 12'h0};
    launch(g);
    wait_end();
    check(walk_fault && !fault_nested && fault_level == 2'd0 && fault_addr == {4'h0, g},
          "R7 leaf fault", {fault_nested, fault_level, fault_addr}, {1'b0, 2'd0, 4'h0, g});
    check(rd_all == 16 && rd_host == 12, "R7 leaf fault reads",
          {rd_all[15:0], rd_host[15:0]}, {16'd16, 16'd12});
    @(negedge clk);

    // R8: host top-level absent for final page
    vp = {9'd5, 9'd1, 9'd2, 9'd3};
    map_guest(vp, 40'h8000_0000);
    launch({vp, 12'h0});
    wait_end();
    check(walk_fault && fault_nested && fault_level == 2'd3 &&
          fault_addr == {40'h8000_0000, 12'h0}, "R8 nested top fault",
          {fault_nested, fault_level, fault_addr}, {1'b1, 2'd3, 40'h8000_0000, 12'h0});
    check(rd_all == 17 && rd_host == 13, "R8 nested top reads",
          {rd_all[15:0], rd_host[15:0]}, {16'd17, 16'd13});
    @(negedge clk);

    // R8: host leaf absent
    vp = {9'd5, 9'd1, 9'd2, 9'd4};
    map_guest(vp, 40'h1001);
    launch({vp, 12'h0});
    wait_end();
    check(walk_fault && fault_nested && fault_level == 2'd0 &&
          fault_addr == {40'h1001, 12'h0}, "R8 nested leaf fault",
          {fault_nested, fault_level, fault_addr}, {1'b1, 2'd0, 40'h1001, 12'h0});
    check(rd_all == 20 && rd_host == 16, "R8 nested leaf reads",
          {rd_all[15:0], rd_host[15:0]}, {16'd20, 16'd16});
    @(negedge clk);

    // R5: request mid-walk ignored
    launch({sweep_vp(4), 12'h0});
    repeat (5) @(negedge clk);
    walk_gva = {9'h1FF, 39'h0};
    walk_req = 1'b1;
    @(negedge clk);
    walk_req = 1'b0;
    wait_end();
    check(walk_done && !walk_fault && result_frame == 40'h9000 + 40'd52,
          "R5 busy request ignored", result_frame, 40'h9000 + 40'd52);
    @(negedge clk);
    check(!walk_busy && !mem_req_valid, "R5 not queued", {walk_busy, mem_req_valid}, 0);

    // R4: stray response while idle
    begin
      bit seen;
      seen = 1'b0;
      stray = 1'b1;
      repeat (4) begin
        @(negedge clk);
        if (walk_busy || walk_done || walk_fault || mem_req_valid) seen = 1'b1;
      end
      check(!seen, "R4 stray response ignored", seen, 0);
    end
    launch({sweep_vp(5), 12'h0});
    wait_end();
    check(walk_done && result_frame == 40'h9000 + 40'd65 && rd_all == 20,
          "R4 walk after stray", result_frame, 40'h9000 + 40'd65);
    @(negedge clk);

    // R9: live tables
    vp = {9'd6, 9'd0, 9'd0, 9'd1};
    map_host(40'h2000, 40'hA000);
    map_host(40'h2001, 40'hA100);
    map_guest(vp, 40'h2000);
    launch({vp, 12'h0});
    wait_end();
    check(walk_done && result_frame == 40'hA000, "R9 first mapping", result_frame, 40'hA000);
    @(negedge clk);
    map_guest(vp, 40'h2001);
    launch({vp, 12'h0});
    wait_end();
    check(walk_done && result_frame == 40'hA100, "R9 rewritten mapping",
          result_frame, 40'hA100);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule